// File: doc/BRIEF.md
# TSF Counter with Beacon Target Timers

This block keeps the time base of a wireless MAC. A 64-bit counter advances once per microsecond and can be loaded or cleared through a small register port. Four 16-bit target timers track the beacon schedule: next beacon time, DMA beacon alert, software beacon alert and ATIM window end. The next-beacon and ATIM timers count in time units (TU, 1024 µs). The two alert timers count in eighths of a TU. When the counter enters the slot a timer names, that timer raises a one-cycle pulse and advances by the beacon interval.

A timer advances only when the counter reaches its value exactly. A counter load that jumps past a timer therefore leaves that timer behind until its 16-bit field wraps. Two window checkers report whether the ATIM timer and the DMA alert timer still sit at their intended offsets from the next-beacon timer. Software can see and repair the drift this way. A single arm write sets all four timers from one next-beacon value.

Register map (addr): 0 counter low half, 1 counter high half, 2 control (bit 0 = clear counter), 3 beacon interval in TU, 4 next-beacon timer, 5 DMA alert timer, 6 software alert timer, 7 ATIM end timer, 8 arm (write) / window status (read: bit 0 ATIM window good, bit 1 DMA window good). Unmapped addresses read 0.

Top module: `tsf_beacon_timer`

## Requirements
- R1: After reset every timer, the interval and the counter are 0. The counter then grows by exactly 1 every CYCLES_PER_US clocks (1 by default), and all pulse outputs and rdValid stay low during reset.
- R2: A write to addr 0 only stages the low half. A write to addr 1 loads {written high, staged low} into the counter one clock after that write is sampled.
- R3: A read of addr 0 returns the low half and captures the high half of the same counter value. A later read of addr 1 returns that captured half, even if the counter has since carried into its upper word. Read data appears with rdValid one clock after rdEn is sampled.
- R4: A write to addr 2 with bit 0 set clears the counter one clock later, once per write. Bit 0 always reads back as 0, and a write with bit 0 clear leaves the counter running.
- R5: The next-beacon and ATIM timers are compared with counter bits [25:10]. On the clock where the counter steps into a value whose bits [25:10] equal the timer, the timer's pulse is raised and the timer is increased by the interval (modulo 2^16).
- R6: The DMA and software alert timers are compared with counter bits [22:7] in the same way. They are increased by the interval times 8.
- R7: A counter load or clear never raises a pulse. A timer that the counter has jumped past keeps its value, because only an exact step-into match moves it.
- R8: A write of value N to addr 8 sets next-beacon = N, DMA alert = (N - DMA_LEAD) << 3, software alert = (N - SW_LEAD) << 3 and ATIM end = N + 1. The defaults are DMA_LEAD = 2 and SW_LEAD = 1, and all results are modulo 2^16.
- R9: The window check of a pair (a, b) with window w and interval i passes when any of these holds: b - a = w, a - b = i - w, (a | 0x10000) - b = i - w, or (b | 0x10000) - a = w. Status bit 0 checks a = next-beacon, b = ATIM, w = 1. Status bit 1 checks a = DMA alert >> 3, b = next-beacon, w = DMA_LEAD.
- R10: Each timer pulse lasts exactly one clock per match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one clock after rdEn |
| rdData | output | 32 | Read data |
| nbttPulse | output | 1 | Next-beacon timer match pulse |
| dmaPulse | output | 1 | DMA beacon alert match pulse |
| swbaPulse | output | 1 | Software beacon alert match pulse |
| atimPulse | output | 1 | ATIM window end match pulse |

## Verification
Two effects can meet across one read pair: the capture of the high half by a low-half read, and the counter's carry into its upper word. To provoke this, the bench loads a value sixteen microseconds below the 32-bit boundary. It reads the low half before the carry and the high half well after it, and expects the pre-carry high word. A second pair read after the carry expects the incremented word. The bench also loads the counter into the middle of a TU that a timer already names. That load must stay silent. The ATIM timer, which the counter reaches later, must fire alone, and the window status must then report the drift.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int TSF_W      = 64;
  localparam int BUS_W      = 32;
  localparam int TMR_W      = 16;
  localparam int ADDR_W     = 4;
  localparam int NUM_TMR    = 4;
  localparam int TU_LSB     = 10;
  localparam int EIGHTH_LSB = 7;

  localparam int IDX_NBTT = 0;
  localparam int IDX_DMA  = 1;
  localparam int IDX_SWBA = 2;
  localparam int IDX_ATIM = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TSF_LO = 4'd0,
    A_TSF_HI = 4'd1,
    A_CTRL   = 4'd2,
    A_INTVL  = 4'd3,
    A_NBTT   = 4'd4,
    A_DMA    = 4'd5,
    A_SWBA   = 4'd6,
    A_ATIM   = 4'd7,
    A_ARM    = 4'd8
  } regAddr_e;

  // Strobes from the register control to the datapath, one clock wide.
  typedef struct packed {
    logic               loadTsf;
    logic               clearTsf;
    logic [TSF_W-1:0]   loadVal;
    logic               wrIntvl;
    logic [NUM_TMR-1:0] wrTimer;
    logic               arm;
    logic [TMR_W-1:0]   value;
  } tsfStrobe_t;
endpackage

// File: rtl/tsf_window_chk.sv
module tsf_window_chk
  import tsf_pkg::*;
(
  input  logic [TMR_W-1:0] a,
  input  logic [TMR_W-1:0] b,
  input  logic [TMR_W-1:0] window,
  input  logic [TMR_W-1:0] intval,
  output logic             ok
);
  localparam int EW = TMR_W + 2;
  localparam logic [EW-1:0] WRAP = EW'(1) << TMR_W;

  logic [EW-1:0] aExt, bExt, wExt, iExt, gap;

  always_comb begin
    aExt = EW'(a);
    bExt = EW'(b);
    wExt = EW'(window);
    iExt = EW'(intval);
    gap  = iExt - wExt;
    ok   = ((bExt - aExt) == wExt)
        || ((aExt - bExt) == gap)
        || (((aExt | WRAP) - bExt) == gap)
        || (((bExt | WRAP) - aExt) == wExt);
  end
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BUS_W-1:0]              wrData,
  input  logic [TSF_W-1:0]              tsf,
  input  logic [TMR_W-1:0]              intvl,
  input  logic [NUM_TMR-1:0][TMR_W-1:0] timers,
  input  logic [1:0]                    winOk,
  output tsfStrobe_t                    stb,
  output logic                          rdValid,
  output logic [BUS_W-1:0]              rdData
);
  logic [BUS_W-1:0] loStage;
  logic [BUS_W-1:0] hiLatch;

  // Write decode: every action is registered into a one-clock strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stb     <= '0;
      loStage <= '0;
    end else begin
      stb <= '0;
      if (wrEn) begin
        case (addr)
          A_TSF_LO: loStage <= wrData;
          A_TSF_HI: begin
            stb.loadTsf <= 1'b1;
            stb.loadVal <= {wrData, loStage};
          end
          A_CTRL:   stb.clearTsf <= wrData[0];
          A_INTVL:  begin stb.wrIntvl <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          A_NBTT:   begin stb.wrTimer[IDX_NBTT] <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          A_DMA:    begin stb.wrTimer[IDX_DMA]  <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          A_SWBA:   begin stb.wrTimer[IDX_SWBA] <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          A_ATIM:   begin stb.wrTimer[IDX_ATIM] <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          A_ARM:    begin stb.arm <= 1'b1; stb.value <= wrData[TMR_W-1:0]; end
          default:  ;
        endcase
      end
    end
  end

  // Read path: low-half read snapshots the high half of the same value.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      hiLatch <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        case (addr)
          A_TSF_LO: begin
            rdData  <= tsf[BUS_W-1:0];
            hiLatch <= tsf[TSF_W-1:BUS_W];
          end
          A_TSF_HI: rdData <= hiLatch;
          A_INTVL:  rdData <= BUS_W'(intvl);
          A_NBTT:   rdData <= BUS_W'(timers[IDX_NBTT]);
          A_DMA:    rdData <= BUS_W'(timers[IDX_DMA]);
          A_SWBA:   rdData <= BUS_W'(timers[IDX_SWBA]);
          A_ATIM:   rdData <= BUS_W'(timers[IDX_ATIM]);
          A_ARM:    rdData <= BUS_W'(winOk);
          default:  rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsf_datapath.sv
module tsf_datapath
  import tsf_pkg::*;
#(
  parameter int CYCLES_PER_US = 1,
  parameter int DMA_LEAD      = 2,
  parameter int SW_LEAD       = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tsfStrobe_t                    stb,
  output logic [TSF_W-1:0]              tsf,
  output logic [TMR_W-1:0]              intvl,
  output logic [NUM_TMR-1:0][TMR_W-1:0] timers,
  output logic [NUM_TMR-1:0]            fire
);
  logic tick;

  generate
    if (CYCLES_PER_US <= 1) begin : g_tickDirect
      assign tick = 1'b1;
    end else begin : g_tickPresc
      localparam int PW = $clog2(CYCLES_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_US - 1);
      logic [PW-1:0] presc;
      always_ff @(posedge clk) begin
        if (!rstN || stb.loadTsf || stb.clearTsf || presc == LAST) presc <= '0;
        else presc <= presc + 1'b1;
      end
      assign tick = (presc == LAST);
    end
  endgenerate

  logic [TSF_W-1:0]               tsfInc;
  logic                           tsfRun, tuEdge, eighthEdge;
  logic [TMR_W-1:0]               tuNow, eighthNow;
  logic [NUM_TMR-1:0]             hit;
  logic [NUM_TMR-1:0][TMR_W-1:0]  step;
  logic [NUM_TMR-1:0][TMR_W-1:0]  armVal;

  always_comb begin
    tsfInc     = tsf + 1'b1;
    tsfRun     = !stb.loadTsf && !stb.clearTsf;
    tuEdge     = tick && tsfRun && (tsfInc[TU_LSB-1:0] == '0);
    eighthEdge = tick && tsfRun && (tsfInc[EIGHTH_LSB-1:0] == '0);
    tuNow      = tsfInc[TU_LSB+TMR_W-1:TU_LSB];
    eighthNow  = tsfInc[EIGHTH_LSB+TMR_W-1:EIGHTH_LSB];

    armVal[IDX_NBTT] = stb.value;
    armVal[IDX_DMA]  = (stb.value - TMR_W'(DMA_LEAD)) << 3;
    armVal[IDX_SWBA] = (stb.value - TMR_W'(SW_LEAD)) << 3;
    armVal[IDX_ATIM] = stb.value + 1'b1;

    for (int i = 0; i < NUM_TMR; i++) begin
      if (i == IDX_DMA || i == IDX_SWBA) begin
        hit[i]  = eighthEdge && (eighthNow == timers[i]);
        step[i] = intvl << 3;
      end else begin
        hit[i]  = tuEdge && (tuNow == timers[i]);
        step[i] = intvl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tsf <= '0;
    else if (stb.clearTsf) tsf <= '0;
    else if (stb.loadTsf)  tsf <= stb.loadVal;
    else if (tick)         tsf <= tsfInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            intvl <= '0;
    else if (stb.wrIntvl) intvl <= stb.value;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timers <= '0;
      fire   <= '0;
    end else begin
      fire <= hit;
      for (int i = 0; i < NUM_TMR; i++) begin
        if (stb.arm)             timers[i] <= armVal[i];
        else if (stb.wrTimer[i]) timers[i] <= stb.value;
        else if (hit[i])         timers[i] <= timers[i] + step[i];
      end
    end
  end
endmodule

// File: rtl/tsf_beacon_timer.sv
module tsf_beacon_timer
  import tsf_pkg::*;
#(
  parameter int CYCLES_PER_US = 1,
  parameter int DMA_LEAD      = 2,
  parameter int SW_LEAD       = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic              rdValid,
  output logic [BUS_W-1:0]  rdData,
  output logic              nbttPulse,
  output logic              dmaPulse,
  output logic              swbaPulse,
  output logic              atimPulse
);
  tsfStrobe_t                    stb;
  logic [TSF_W-1:0]              tsfVal;
  logic [TMR_W-1:0]              intvl;
  logic [NUM_TMR-1:0][TMR_W-1:0] tmr;
  logic [NUM_TMR-1:0]            fire;
  logic [1:0]                    winOk;

  tsf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .tsf(tsfVal), .intvl(intvl), .timers(tmr),
    .winOk(winOk), .stb(stb), .rdValid(rdValid), .rdData(rdData)
  );

  tsf_datapath #(
    .CYCLES_PER_US(CYCLES_PER_US), .DMA_LEAD(DMA_LEAD), .SW_LEAD(SW_LEAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tsf(tsfVal), .intvl(intvl),
    .timers(tmr), .fire(fire)
  );

  tsf_window_chk u_winAtim (
    .a(tmr[IDX_NBTT]), .b(tmr[IDX_ATIM]), .window(TMR_W'(1)),
    .intval(intvl), .ok(winOk[0])
  );

  tsf_window_chk u_winDma (
    .a(tmr[IDX_DMA] >> 3), .b(tmr[IDX_NBTT]), .window(TMR_W'(DMA_LEAD)),
    .intval(intvl), .ok(winOk[1])
  );

  assign nbttPulse = fire[IDX_NBTT];
  assign dmaPulse  = fire[IDX_DMA];
  assign swbaPulse = fire[IDX_SWBA];
  assign atimPulse = fire[IDX_ATIM];
endmodule

// File: rtl/tsf_beacon_timer_sva.sv
module tsf_beacon_timer_sva
  import tsf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [TSF_W-1:0] tsf,
  input logic             loadTsf,
  input logic             clearTsf,
  input logic [TSF_W-1:0] loadVal,
  input logic [TMR_W-1:0] nbtt,
  input logic [TMR_W-1:0] dma,
  input logic             nbttPulse,
  input logic             dmaPulse,
  input logic             atimPulse
);
  a_r1_tsf_step: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadTsf) && !$past(clearTsf)) |->
      (tsf == $past(tsf) || tsf == $past(tsf) + 64'd1));

  a_r2_tsf_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadTsf) && !$past(clearTsf)) |-> tsf == $past(loadVal));

  a_r4_tsf_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearTsf) |-> tsf == '0);

  a_r5_tu_match: assert property (@(posedge clk) disable iff (!rstN)
    nbttPulse |-> (tsf[TU_LSB+TMR_W-1:TU_LSB] == $past(nbtt)) && (tsf[TU_LSB-1:0] == '0));

  a_r6_eighth_match: assert property (@(posedge clk) disable iff (!rstN)
    dmaPulse |-> (tsf[EIGHTH_LSB+TMR_W-1:EIGHTH_LSB] == $past(dma)) && (tsf[EIGHTH_LSB-1:0] == '0));

  a_r7_no_fire_on_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadTsf) || $past(clearTsf)) |-> !nbttPulse && !dmaPulse && !atimPulse);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    atimPulse |=> !atimPulse);
endmodule

bind tsf_beacon_timer tsf_beacon_timer_sva u_sva (
  .clk(clk), .rstN(rstN), .tsf(tsfVal), .loadTsf(stb.loadTsf),
  .clearTsf(stb.clearTsf), .loadVal(stb.loadVal), .nbtt(tmr[0]), .dma(tmr[1]),
  .nbttPulse(nbttPulse), .dmaPulse(dmaPulse), .atimPulse(atimPulse)
);

// File: tb/tsf_beacon_timer_bench.sv
module tsf_beacon_timer_bench;
  import tsf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0] wrData = '0;
  logic rdValid;
  logic [BUS_W-1:0] rdData;
  logic nbttPulse, dmaPulse, swbaPulse, atimPulse;

  int nChecks = 0, nFail = 0;
  int nCnt = 0, dCnt = 0, sCnt = 0, aCnt = 0;

  string tagQ[$];
  logic [BUS_W-1:0] maskQ[$];
  logic [BUS_W-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsf_beacon_timer u_tsf_beacon_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .nbttPulse(nbttPulse), .dmaPulse(dmaPulse), .swbaPulse(swbaPulse),
    .atimPulse(atimPulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pulse monitor: counts clocks each pulse is high, sampled mid-cycle.
  always @(negedge clk) begin
    if (rstN) begin
      if (nbttPulse) nCnt++;
      if (dmaPulse)  dCnt++;
      if (swbaPulse) sCnt++;
      if (atimPulse) aCnt++;
    end
  end

  // Scoreboard monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R3 unexpected read actual=%0h expected=none", rdData);
      end else begin
        automatic string t = tagQ.pop_front();
        automatic logic [BUS_W-1:0] m = maskQ.pop_front();
        automatic logic [BUS_W-1:0] e = expQ.pop_front();
        check(t, 64'(rdData & m), 64'(e));
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] m,
                       input logic [BUS_W-1:0] e, input string tag);
    tagQ.push_back(tag); maskQ.push_back(m); expQ.push_back(e);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTsf(input logic [63:0] v);
    wr(A_TSF_LO, v[31:0]);
    wr(A_TSF_HI, v[63:32]);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int nb, db, sb, ab;
    idle(3);
    check("R1 reset rdValid", 64'(rdValid), 0);
    check("R1 reset pulses", 64'({nbttPulse, dmaPulse, swbaPulse, atimPulse}), 0);
    check("R1 reset rdData", 64'(rdData), 0);
    rstN = 1'b1;
    rdExp(A_INTVL, 32'hFFFF_FFFF, 0, "R1");
    rdExp(A_NBTT, 32'hFFFF_FFFF, 0, "R1");
    rdExp(A_ATIM, 32'hFFFF_FFFF, 0, "R1");
    rdExp(A_TSF_LO, 32'hFFFF_FF00, 0, "R1");

    // R2/R3: load 16 below the 32-bit boundary, read across the carry.
    wr(A_TSF_LO, 32'hFFFF_FFF0);
    wr(A_TSF_HI, 32'h0000_0005);
    rdExp(A_TSF_LO, 32'hFFFF_FFFF, 32'hFFFF_FFF0, "R2");
    rdExp(A_TSF_LO, 32'hFFFF_FFFF, 32'hFFFF_FFF2, "R1");
    idle(40);
    rdExp(A_TSF_HI, 32'hFFFF_FFFF, 32'h5, "R3");
    rdExp(A_TSF_LO, 32'hFFFF_FF00, 0, "R3");
    rdExp(A_TSF_HI, 32'hFFFF_FFFF, 32'h6, "R3");

    // R4: clear pulse, readback, and a write with bit 0 low.
    wr(A_CTRL, 32'h1);
    rdExp(A_TSF_LO, 32'hFFFF_FFFF, 0, "R4");
    rdExp(A_TSF_HI, 32'hFFFF_FFFF, 0, "R4");
    rdExp(A_CTRL, 32'hFFFF_FFFF, 0, "R4");
    loadTsf(64'h0000_0001_0000_1000);
    wr(A_CTRL, 32'h0);
    rdExp(A_TSF_LO, 32'hFFFF_FFFF, 32'h0000_1002, "R4");
    rdExp(A_TSF_HI, 32'hFFFF_FFFF, 32'h1, "R4");

    // R8/R9: arm from one next-beacon value.
    wr(A_INTVL, 100);
    wr(A_ARM, 32'h0123);
    idle(2);
    rdExp(A_NBTT, 32'hFFFF_FFFF, 32'h0123, "R8");
    rdExp(A_DMA,  32'hFFFF_FFFF, 32'h0908, "R8");
    rdExp(A_SWBA, 32'hFFFF_FFFF, 32'h0910, "R8");
    rdExp(A_ATIM, 32'hFFFF_FFFF, 32'h0124, "R8");
    rdExp(A_ARM,  32'hFFFF_FFFF, 32'h3, "R9");

    // R9: each acceptance case, then two drifted windows.
    wr(A_NBTT, 32'h0200); wr(A_ATIM, 32'h019D); idle(1);
    rdExp(A_ARM, 32'h1, 32'h1, "R9");
    wr(A_NBTT, 32'h0010); wr(A_ATIM, 32'hFFAD); idle(1);
    rdExp(A_ARM, 32'h1, 32'h1, "R9");
    wr(A_NBTT, 32'hFFFF); wr(A_ATIM, 32'h0000); idle(1);
    rdExp(A_ARM, 32'h1, 32'h1, "R9");
    wr(A_NBTT, 32'h0200); wr(A_ATIM, 32'h0205); idle(1);
    rdExp(A_ARM, 32'h1, 32'h0, "R9");
    wr(A_NBTT, 32'h0150); idle(1);
    rdExp(A_ARM, 32'h2, 32'h0, "R9");

    // R5/R10: next-beacon timer match in TU.
    wr(A_NBTT, 10); wr(A_ATIM, 32'h3000); wr(A_DMA, 32'hF000); wr(A_SWBA, 32'hF000);
    nb = nCnt; db = dCnt; sb = sCnt; ab = aCnt;
    loadTsf(64'h27F0);
    idle(40);
    check("R5 nbtt pulse count", 64'(nCnt - nb), 1);
    check("R10 other pulses quiet", 64'((dCnt - db) + (sCnt - sb) + (aCnt - ab)), 0);
    rdExp(A_NBTT, 32'hFFFF_FFFF, 110, "R5");

    // R6: alert timers in 1/8 TU, advance by interval*8.
    wr(A_DMA, 32'h51); wr(A_SWBA, 32'h52);
    nb = nCnt; db = dCnt; sb = sCnt;
    loadTsf(64'h27F0);
    idle(300);
    check("R6 dma pulse count", 64'(dCnt - db), 1);
    check("R6 swba pulse count", 64'(sCnt - sb), 1);
    check("R7 nbtt quiet", 64'(nCnt - nb), 0);
    rdExp(A_DMA, 32'hFFFF_FFFF, 32'h371, "R6");
    rdExp(A_SWBA, 32'hFFFF_FFFF, 32'h372, "R6");

    // R7: load lands inside the TU a timer names; that timer stalls.
    wr(A_NBTT, 10); wr(A_ATIM, 11);
    nb = nCnt; ab = aCnt;
    loadTsf(64'h2900);
    idle(3);
    check("R7 no pulse on load", 64'(nCnt - nb), 0);
    idle(800);
    check("R7 stalled timer silent", 64'(nCnt - nb), 0);
    check("R5 atim pulse count", 64'(aCnt - ab), 1);
    rdExp(A_NBTT, 32'hFFFF_FFFF, 10, "R7");
    rdExp(A_ATIM, 32'hFFFF_FFFF, 111, "R5");
    rdExp(A_ARM, 32'h1, 32'h0, "R9");

    idle(4);
    check("R3 scoreboard drained", 64'(expQ.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule